// File: doc/BRIEF.md
# Tag Store with Built-in Equality Comparator

This block holds the tag half of a direct-mapped cache. It is an array of `2**IDX_W` words, each `TAG_W` bits wide, addressed by the low part of the physical address (the index). The high address bits are presented on the data input and compared with the word stored at that index. A hit/miss line, `match_o`, reports the result. High means "equal or not comparing" and low means "mismatch". Several stores can cover a wider tag: the system ANDs their `match_o` lines, so one mismatch anywhere gives an overall miss. Two 8-bit stores give 16 compared bits. One bit of the upper store's tag can be tied to 1 to act as a valid flag. A cleared word is all zeros, so it then never reports a hit.

Four active-low controls select the operation: clear, chip select, write enable and output enable. The operations are whole-array clear, deselect, tag compare, plain read and plain write. The data port is split into an input bus, an output bus and an output-enable flag, so it can model a bidirectional pin. The clear is carried out by a sequencer. It writes one word per clock and raises `busy_o` while it runs. The same sequencer runs on its own after reset, so the store is empty before the first access is accepted. All outputs are registered. A result appears one clock after its inputs are sampled.

Default parameters give 2048 words of 8 bits. `IDX_W` = 13 gives 8192 words.

Top module: `tag_cmp_store`

## Requirements
- R1: After reset is released, `busy_o` stays high for exactly `2**IDX_W + 2` rising edges. These are two edges of reset release plus one edge per word. While `busy_o` is high, `match_o` is 1 and `dout_en` is 0.
- R2: After a clear, every word of the array reads back as zero.
- R3: While `busy_o` is high, a write, read or compare request has no effect. No word changes, `match_o` stays 1 and `dout_en` stays 0.
- R4: With `cs_n` = 1 (deselect), `dout_en` is 0 and `match_o` is 1 on the next clock. A write attempted with `cs_n` = 1 leaves the indexed word unchanged.
- R5: Compare mode is `cs_n` = 0, `we_n` = 1 and `oe_n` = 1. One clock later, `match_o` is 0 if the word at `idx` differs from `din`, and 1 if it equals `din`.
- R6: Read mode is `cs_n` = 0, `we_n` = 1 and `oe_n` = 0. One clock later, `dout` holds the word at `idx`, `dout_en` is 1 and `match_o` is 1.
- R7: Write mode is `cs_n` = 0 and `we_n` = 0, whatever the value of `oe_n`. It stores `din` at `idx`. One clock later, `dout_en` is 0 and `match_o` is 1.
- R8: `clr_n` = 0 overrides every other control. No write takes place, `match_o` is 1 and `dout_en` is 0 on the next clock, and `busy_o` is 1.
- R9: Holding `clr_n` low for several cycles keeps `busy_o` high. After `clr_n` returns to 1, `busy_o` falls exactly `2**IDX_W` rising edges later.
- R10: A cleared word compares equal only to an all-zero tag. A tag with bit 7 set (the valid flag) misses on a cleared word. It hits only after the same tag has been written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_n | input | 1 | Active-low whole-array clear request |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| idx | input | IDX_W | Word index (low address bits) |
| din | input | TAG_W | Write data or compare tag |
| dout | output | TAG_W | Read data |
| dout_en | output | 1 | High when `dout` drives the data bus |
| match_o | output | 1 | 0 = tag mismatch; 1 = hit or not comparing |
| busy_o | output | 1 | High while the clear sequencer walks the array |

## Verification
The hardest case to reach from the ports is a request that lands while the clear walk is running. It must leave no trace, even though the sequencer is writing into the same array on every cycle. The stimulus starts a one-cycle clear. It then issues a write, a read and a mismatching compare at a word the walk has not yet reached. After `busy_o` falls, it reads that word back to prove that only the zero written by the walk remains. A held clear that overlaps an active write strobe is also driven, and the length of the busy window is counted edge by edge.

// File: rtl/tagcmp_pkg.sv
package tagcmp_pkg;

  // Operation selected for the current cycle by the control pins.
  typedef enum logic [2:0] {
    MD_IDLE  = 3'd0,  // deselected, or request ignored while busy
    MD_CLEAR = 3'd1,  // clear request present
    MD_CMP   = 3'd2,  // tag compare
    MD_READ  = 3'd3,  // plain read
    MD_WRITE = 3'd4   // plain write
  } tc_mode_e;

endpackage

// File: rtl/tagcmp_decode.sv
module tagcmp_decode
  import tagcmp_pkg::*;
(
  input  logic     busy,
  input  logic     clr_n,
  input  logic     cs_n,
  input  logic     we_n,
  input  logic     oe_n,
  output tc_mode_e mode
);

  // Priority: clear, then busy/deselect, then write, read, compare.
  always_comb begin
    if (!clr_n)              mode = MD_CLEAR;
    else if (busy || cs_n)   mode = MD_IDLE;
    else if (!we_n)          mode = MD_WRITE;
    else if (!oe_n)          mode = MD_READ;
    else                     mode = MD_CMP;
  end

endmodule

// File: rtl/tagcmp_clear_seq.sv
module tagcmp_clear_seq #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_req,
  output logic             busy,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_ptr
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W:0] FULL = (IDX_W+1)'(DEPTH);

  logic [IDX_W:0]   left_q, left_n;
  logic [IDX_W-1:0] ptr_q, ptr_n;

  assign busy   = (left_q != '0);
  assign wr_en  = busy || clr_req;
  assign wr_ptr = ptr_q;

  // A request reloads the count of words still to clear; the pointer keeps
  // walking, so the last FULL writes after release cover every word.
  always_comb begin
    left_n = left_q;
    ptr_n  = ptr_q;
    if (clr_req)   left_n = FULL;
    else if (busy) left_n = left_q - 1'b1;
    if (wr_en)     ptr_n  = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= FULL;
      ptr_q  <= '0;
    end else begin
      left_q <= left_n;
      ptr_q  <= ptr_n;
    end
  end

  // R9: a clear request always leaves the sequencer busy on the next cycle
  a_r9_clear_reload: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> busy);

endmodule

// File: rtl/tagcmp_array.sv
module tagcmp_array #(
  parameter int IDX_W = 11,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [TAG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [TAG_W-1:0] rd_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] mem [DEPTH];

  // Storage carries no reset; the clear sequencer initialises it.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/tagcmp_outreg.sv
module tagcmp_outreg
  import tagcmp_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tc_mode_e         mode,
  input  logic [TAG_W-1:0] stored,
  input  logic [TAG_W-1:0] din,
  output logic [TAG_W-1:0] dout,
  output logic             dout_en,
  output logic             match_o
);

  logic [TAG_W-1:0] dout_q, dout_n;
  logic             en_q, en_n;
  logic             hit_q, hit_n;
  logic             dout_ld;

  assign dout_ld = (mode == MD_READ);

  always_comb begin
    hit_n  = 1'b1;
    en_n   = 1'b0;
    dout_n = dout_q;
    if (mode == MD_CMP)  hit_n  = (stored == din);
    if (dout_ld) begin
      en_n   = 1'b1;
      dout_n = stored;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b1;
      en_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      hit_q <= hit_n;
      en_q  <= en_n;
      if (dout_ld) dout_q <= dout_n;
    end
  end

  assign dout    = dout_q;
  assign dout_en = en_q;
  assign match_o = hit_q;

endmodule

// File: rtl/tag_cmp_store.sv
module tag_cmp_store
  import tagcmp_pkg::*;
#(
  parameter int IDX_W = 11,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             cs_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] din,
  output logic [TAG_W-1:0] dout,
  output logic             dout_en,
  output logic             match_o,
  output logic             busy_o
);

  logic rst_meta_q, rst_sync_q;

  // Reset asserts at once and is released two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             busy;
  logic             clr_wr;
  logic [IDX_W-1:0] clr_ptr;
  tc_mode_e         mode;
  logic             arr_we;
  logic [IDX_W-1:0] arr_waddr;
  logic [TAG_W-1:0] arr_wdata;
  logic [TAG_W-1:0] stored;

  tagcmp_clear_seq #(.IDX_W(IDX_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .clr_req (!clr_n),
    .busy    (busy),
    .wr_en   (clr_wr),
    .wr_ptr  (clr_ptr)
  );

  tagcmp_decode u_dec (
    .busy  (busy),
    .clr_n (clr_n),
    .cs_n  (cs_n),
    .we_n  (we_n),
    .oe_n  (oe_n),
    .mode  (mode)
  );

  // The clear walk owns the write port; user writes only reach it when idle.
  always_comb begin
    arr_we    = 1'b0;
    arr_waddr = idx;
    arr_wdata = din;
    if (clr_wr) begin
      arr_we    = 1'b1;
      arr_waddr = clr_ptr;
      arr_wdata = '0;
    end else if (mode == MD_WRITE) begin
      arr_we    = 1'b1;
    end
  end

  tagcmp_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_arr (
    .clk     (clk),
    .wr_en   (arr_we),
    .wr_addr (arr_waddr),
    .wr_data (arr_wdata),
    .rd_addr (idx),
    .rd_data (stored)
  );

  tagcmp_outreg #(.TAG_W(TAG_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .mode    (mode),
    .stored  (stored),
    .din     (din),
    .dout    (dout),
    .dout_en (dout_en),
    .match_o (match_o)
  );

  assign busy_o = busy;

  // R1 / R3: while walking, the outputs stay quiet
  a_r1_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (match_o && !dout_en));

  // R4: deselect releases the bus and the hit line
  a_r4_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !busy_o && cs_n) |=> (match_o && !dout_en));

  // R6: a read drives the bus without pulling the hit line
  a_r6_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !busy_o && !cs_n && we_n && !oe_n) |=> (dout_en && match_o));

  // R7: a write never drives the bus or reports a miss
  a_r7_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !busy_o && !cs_n && !we_n) |=> (match_o && !dout_en));

  // R8: a clear request overrides everything
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (match_o && !dout_en && busy_o));

endmodule

// File: tb/tag_cmp_store_test.sv
module tag_cmp_store_test;

  localparam int PERIOD = 10;
  localparam int IDX_W  = 11;
  localparam int TAG_W  = 8;
  localparam int DEPTH  = 1 << IDX_W;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic             rst_n, clr_n, cs_n, we_n, oe_n;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] din;
  logic [TAG_W-1:0] dout;
  logic             dout_en, match_o, busy_o;

  int checks = 0;
  int errors = 0;
  logic [TAG_W-1:0] model [DEPTH];

  tag_cmp_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .we_n(we_n),
    .oe_n(oe_n), .idx(idx), .din(din), .dout(dout), .dout_en(dout_en),
    .match_o(match_o), .busy_o(busy_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    clr_n = 1'b1; cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  // Drive one cycle at a falling edge; outputs are valid at the next one.
  task automatic cyc(input logic c, input logic s, input logic w,
                     input logic o, input int i, input int d);
    clr_n = c; cs_n = s; we_n = w; oe_n = o;
    idx = IDX_W'(i); din = TAG_W'(d);
    @(negedge clk);
    go_idle();
  endtask

  task automatic wait_walk(output int n);
    n = 0;
    while (busy_o) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wr(input int i, input int d);
    cyc(1, 0, 0, 1, i, d);
    model[i] = TAG_W'(d);
  endtask

  task automatic pulse_clear();
    int n;
    cyc(0, 1, 1, 1, 0, 0);
    wait_walk(n);
    for (int k = 0; k < DEPTH; k++) model[k] = '0;
  endtask

  task automatic t_reset();
    int n;
    rst_n = 1'b0; go_idle(); idx = '0; din = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy_o, 1);
    chk("R1 match in reset", match_o, 1);
    chk("R1 dout_en in reset", dout_en, 0);
    rst_n = 1'b1;
    wait_walk(n);
    chk("R1 busy length after reset", n, DEPTH + 2);
    for (int k = 0; k < DEPTH; k++) model[k] = '0;
  endtask

  task automatic t_read_all_zero();
    int bad = 0;
    for (int k = 0; k < DEPTH; k++) begin
      cyc(1, 0, 1, 0, k, 0);
      if (dout !== '0 || dout_en !== 1'b1) bad++;
    end
    chk("R2 words not zero after clear", bad, 0);
  endtask

  task automatic t_write_read();
    wr(3, 8'h5a);
    chk("R7 dout_en after write", dout_en, 0);
    chk("R7 match after write", match_o, 1);
    wr(DEPTH-1, 8'hc3);
    cyc(1, 0, 1, 0, 3, 0);
    chk("R6 read data", dout, 8'h5a);
    chk("R6 read enable", dout_en, 1);
    chk("R6 match during read", match_o, 1);
    cyc(1, 0, 1, 0, DEPTH-1, 0);
    chk("R6 read top word", dout, 8'hc3);
    cyc(0 + 1, 0, 0, 0, 4, 8'h77);  // write with oe_n low
    model[4] = 8'h77;
    chk("R7 oe low write dout_en", dout_en, 0);
    cyc(1, 0, 1, 0, 4, 0);
    chk("R7 oe low write stored", dout, 8'h77);
  endtask

  task automatic t_compare();
    cyc(1, 0, 1, 1, 3, 8'h5a);
    chk("R5 equal tag hit", match_o, 1);
    cyc(1, 0, 1, 1, 3, 8'h5b);
    chk("R5 one-bit mismatch", match_o, 0);
    cyc(1, 0, 1, 1, DEPTH-1, 8'h43);
    chk("R5 top-bit mismatch", match_o, 0);
    cyc(1, 0, 1, 1, DEPTH-1, 8'hc3);
    chk("R5 top word hit", match_o, 1);
  endtask

  task automatic t_deselect();
    cyc(1, 1, 0, 0, 3, 8'hee);
    chk("R4 deselect dout_en", dout_en, 0);
    chk("R4 deselect match", match_o, 1);
    cyc(1, 0, 1, 0, 3, 0);
    chk("R4 deselected write ignored", dout, model[3]);
  endtask

  task automatic t_busy_ignore();
    int n;
    cyc(0, 1, 1, 1, 0, 0);
    cyc(1, 0, 0, 1, DEPTH-5, 8'haa);
    chk("R3 write while busy dout_en", dout_en, 0);
    cyc(1, 0, 1, 0, DEPTH-5, 0);
    chk("R3 read while busy dout_en", dout_en, 0);
    cyc(1, 0, 1, 1, DEPTH-5, 8'h33);
    chk("R3 compare while busy match", match_o, 1);
    wait_walk(n);
    for (int k = 0; k < DEPTH; k++) model[k] = '0;
    cyc(1, 0, 1, 0, DEPTH-5, 0);
    chk("R3 busy write left no trace", dout, 0);
  endtask

  task automatic t_clear_hold();
    int n;
    wr(6, 8'h12);
    clr_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 busy while clear held", busy_o, 1);
    clr_n = 1'b1;
    wait_walk(n);
    for (int k = 0; k < DEPTH; k++) model[k] = '0;
    chk("R9 busy length after release", n, DEPTH);
    cyc(1, 0, 1, 0, 6, 0);
    chk("R2 held clear zeroed word", dout, 0);
  endtask

  task automatic t_clear_wins();
    int n;
    wr(7, 8'h44);
    cyc(0, 0, 0, 0, 7, 8'h99);
    chk("R8 match under clear", match_o, 1);
    chk("R8 dout_en under clear", dout_en, 0);
    chk("R8 busy under clear", busy_o, 1);
    wait_walk(n);
    for (int k = 0; k < DEPTH; k++) model[k] = '0;
    cyc(1, 0, 1, 0, 7, 0);
    chk("R8 write under clear dropped", dout, 0);
  endtask

  task automatic t_valid_bit();
    pulse_clear();
    cyc(1, 0, 1, 1, 9, 8'h00);
    chk("R10 zero tag hits cleared word", match_o, 1);
    cyc(1, 0, 1, 1, 9, 8'h80);
    chk("R10 valid tag misses cleared word", match_o, 0);
    wr(9, 8'h95);
    cyc(1, 0, 1, 1, 9, 8'h95);
    chk("R10 valid tag hits after write", match_o, 1);
    cyc(1, 0, 1, 1, 9, 8'h15);
    chk("R10 tag without valid bit misses", match_o, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_read_all_zero();
    t_write_read();
    t_compare();
    t_deselect();
    t_busy_ignore();
    t_clear_hold();
    t_clear_wins();
    t_valid_bit();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule